// File: doc/BRIEF.md
# Power-State Change Notifier

This block sits between a host-side power management control/status register and a local bus that has no path to read that register. The host owns the register in its own clock domain. Whenever the host writes a new value into the two-bit power state field, the local side is told with a single active-low strobe in the local clock domain. Logic outside the block latches the new state and keeps any history.

In the other direction, the local side raises a wake-up request input. A rising edge on that input sets a sticky wake status bit in the host register. When the matching event-enable bit is also set, an active-low event line toward the host is driven low. Software clears the status by writing a one to it.

The host write converts to a toggle flag in the host domain. A two-flop synchronizer and an edge detector in the local domain turn that flag into the strobe. The wake input passes through its own synchronizer into the host domain. Only its rising edge sets the status bit, so a request that stays high cannot set the bit again right after software clears it.

Top module: `pmn_notifier`

## Requirements
- R1: After reset, `reg_rdata` reads 0x0000, `evt_n` is high and `state_pulse_n` is high.
- R2: Register layout: bits 1:0 hold the power state and bit 8 holds the event enable, and both are written by `reg_wr`. Bit 15 is the wake status. Every other bit reads 0.
- R3: A write that changes the value of bits 1:0 produces exactly one low strobe on `state_pulse_n`. The strobe starts within four local clock periods after the write edge.
- R4: Each low strobe on `state_pulse_n` lasts exactly one `lclk` cycle, including when state changes are repeated.
- R5: A write that leaves bits 1:0 unchanged produces no strobe. This holds even when other bits are written.
- R6: A rising edge on `wake_req` sets bit 15 on the third `hclk` rising edge after the input rises. Before that edge, bit 15 reads 0.
- R7: `evt_n` is low exactly when bit 15 and bit 8 are both 1.
- R8: A write with bit 15 = 1 clears the wake status. A write with bit 15 = 0 leaves the status unchanged.
- R9: If `wake_req` stays high after the status is cleared, the status stays 0. It is set again only by a new rising edge on `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst | input | 1 | Host synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read value |
| evt_n | output | 1 | Power-management event to host, active low |
| lclk | input | 1 | Local clock |
| lrst | input | 1 | Local synchronous reset, active high |
| wake_req | input | 1 | Local wake-up request, asynchronous to hclk |
| state_pulse_n | output | 1 | Power-state change strobe, active low, one lclk wide |

## Verification
Register fields and `evt_n` take their new values at the same `hclk` edge that accepts the write. The bench reads them at the falling edge that follows. The wake status appears on the third `hclk` rising edge after `wake_req` rises. The bench samples bit 15 after two rising edges, where it must still be 0, and again after three, where it must be 1.

The local strobe can begin up to four `lclk` periods after the write, depending on where the clock phases fall. For that reason the bench does not count a fixed edge. A falling-edge monitor counts strobes and flags any strobe wider than one cycle, and the bench reads those counters after a window of eight local periods.

// File: rtl/pmn_pkg.sv
package pmn_pkg;
    localparam int REG_W      = 16;
    localparam int PS_W       = 2;
    localparam int PS_LSB     = 0;
    localparam int EV_EN_BIT  = 8;
    localparam int EV_ST_BIT  = 15;

    typedef logic [PS_W-1:0] pstate_t;

    typedef struct packed {
        logic    ev_status;
        logic    ev_enable;
        pstate_t pstate;
    } pm_fields_t;

    localparam pm_fields_t PM_RESET = '{ev_status: 1'b0, ev_enable: 1'b0, pstate: '0};

    function automatic logic [REG_W-1:0] pm_pack(pm_fields_t f);
        logic [REG_W-1:0] r;
        r = '0;
        r[PS_LSB +: PS_W] = f.pstate;
        r[EV_EN_BIT]      = f.ev_enable;
        r[EV_ST_BIT]      = f.ev_status;
        return r;
    endfunction

    function automatic pstate_t pm_state_of(logic [REG_W-1:0] w);
        return w[PS_LSB +: PS_W];
    endfunction
endpackage

// File: rtl/pmn_sync.sv
module pmn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pmn_host_reg.sv
module pmn_host_reg
    import pmn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             wake_async,
    output logic [REG_W-1:0] rdata,
    output logic             evt_n,
    output logic             chg_toggle,
    output logic             wake_rise
);
    pm_fields_t fields_q, fields_d;
    logic       wake_s, wake_prev, tog_q;
    logic       state_changes, clear_hit;

    pmn_sync #(.STAGES(SYNC_STAGES)) u_wake_sync (
        .clk (clk),
        .rst (rst),
        .d   (wake_async),
        .q   (wake_s)
    );

    always_ff @(posedge clk) begin
        if (rst) wake_prev <= 1'b0;
        else     wake_prev <= wake_s;
    end

    assign wake_rise     = wake_s & ~wake_prev;
    assign state_changes = wr && (pm_state_of(wdata) != fields_q.pstate);
    assign clear_hit     = wr && wdata[EV_ST_BIT];

    always_comb begin
        fields_d = fields_q;
        if (wr) begin
            fields_d.pstate    = pm_state_of(wdata);
            fields_d.ev_enable = wdata[EV_EN_BIT];
        end
        // a new wake edge outranks a clear landing in the same cycle
        fields_d.ev_status = (fields_q.ev_status & ~clear_hit) | wake_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= PM_RESET;
            tog_q    <= 1'b0;
        end else begin
            fields_q <= fields_d;
            if (state_changes) tog_q <= ~tog_q;
        end
    end

    assign rdata      = pm_pack(fields_q);
    assign evt_n      = ~(fields_q.ev_status & fields_q.ev_enable);
    assign chg_toggle = tog_q;
endmodule

// File: rtl/pmn_local_pulse.sv
module pmn_local_pulse #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_async,
    output logic pulse_n
);
    logic tog_s, tog_prev, pulse_n_q;

    pmn_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
        .clk (clk),
        .rst (rst),
        .d   (tog_async),
        .q   (tog_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_prev  <= 1'b0;
            pulse_n_q <= 1'b1;
        end else begin
            tog_prev  <= tog_s;
            pulse_n_q <= ~(tog_s ^ tog_prev);
        end
    end

    assign pulse_n = pulse_n_q;
endmodule

// File: rtl/pmn_notifier.sv
module pmn_notifier
    import pmn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             hclk,
    input  logic             hrst,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             evt_n,
    input  logic             lclk,
    input  logic             lrst,
    input  logic             wake_req,
    output logic             state_pulse_n
);
    logic toggle_w, wake_rise_w;

    pmn_host_reg #(.SYNC_STAGES(SYNC_STAGES)) u_host (
        .clk        (hclk),
        .rst        (hrst),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .wake_async (wake_req),
        .rdata      (reg_rdata),
        .evt_n      (evt_n),
        .chg_toggle (toggle_w),
        .wake_rise  (wake_rise_w)
    );

    pmn_local_pulse #(.SYNC_STAGES(SYNC_STAGES)) u_local (
        .clk       (lclk),
        .rst       (lrst),
        .tog_async (toggle_w),
        .pulse_n   (state_pulse_n)
    );
endmodule

// File: rtl/pmn_notifier_chk.sv
module pmn_notifier_chk
    import pmn_pkg::*;
(
    input logic             hclk,
    input logic             hrst,
    input logic             lclk,
    input logic             lrst,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             evt_n,
    input logic             state_pulse_n,
    input logic             toggle,
    input logic             wake_rise
);
    AST_HOST_RESET: assert property (@(posedge hclk) hrst |=> (reg_rdata == '0 && evt_n)); // R1
    AST_LOCAL_RESET: assert property (@(posedge lclk) lrst |=> state_pulse_n); // R1
    AST_STATE_HOLD: assert property (@(posedge hclk) disable iff (hrst) !reg_wr |=> $stable(reg_rdata[PS_LSB +: PS_W])); // R2
    AST_TOGGLE_ON_CHANGE: assert property (@(posedge hclk) disable iff (hrst) (reg_wr && reg_wdata[PS_LSB +: PS_W] != reg_rdata[PS_LSB +: PS_W]) |=> (toggle != $past(toggle))); // R3
    AST_NO_TOGGLE_SAME: assert property (@(posedge hclk) disable iff (hrst) (reg_wr && reg_wdata[PS_LSB +: PS_W] == reg_rdata[PS_LSB +: PS_W]) |=> $stable(toggle)); // R5
    AST_PULSE_ONE_CYCLE: assert property (@(posedge lclk) disable iff (lrst) !state_pulse_n |=> state_pulse_n); // R4
    AST_WAKE_SETS: assert property (@(posedge hclk) disable iff (hrst) wake_rise |=> reg_rdata[EV_ST_BIT]); // R6
    AST_CLEAR_W1C: assert property (@(posedge hclk) disable iff (hrst) (reg_wr && reg_wdata[EV_ST_BIT] && !wake_rise) |=> !reg_rdata[EV_ST_BIT]); // R8
    AST_STATUS_STICKY: assert property (@(posedge hclk) disable iff (hrst) (reg_rdata[EV_ST_BIT] && !(reg_wr && reg_wdata[EV_ST_BIT])) |=> reg_rdata[EV_ST_BIT]); // R8
    AST_NO_SPURIOUS_SET: assert property (@(posedge hclk) disable iff (hrst) (!reg_rdata[EV_ST_BIT] && !wake_rise) |=> !reg_rdata[EV_ST_BIT]); // R9
    AST_EVT_NEEDS_ENABLE: assert property (@(posedge hclk) disable iff (hrst) !reg_rdata[EV_EN_BIT] |-> evt_n); // R7
endmodule

bind pmn_notifier pmn_notifier_chk u_chk (
    .hclk          (hclk),
    .hrst          (hrst),
    .lclk          (lclk),
    .lrst          (lrst),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .evt_n         (evt_n),
    .state_pulse_n (state_pulse_n),
    .toggle        (toggle_w),
    .wake_rise     (wake_rise_w)
);

// File: tb/pmn_notifier_test.sv
module pmn_notifier_test;
    logic        hclk = 1'b0;
    logic        lclk = 1'b0;
    logic        hrst = 1'b1;
    logic        lrst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        evt_n;
    logic        wake_req = 1'b0;
    logic        state_pulse_n;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int wide   = 0;
    logic prev_low = 1'b0;

    always #5 hclk = ~hclk;
    always #8 lclk = ~lclk;

    pmn_notifier uut (
        .hclk          (hclk),
        .hrst          (hrst),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .evt_n         (evt_n),
        .lclk          (lclk),
        .lrst          (lrst),
        .wake_req      (wake_req),
        .state_pulse_n (state_pulse_n)
    );

    // strobe monitor, sampled away from the local active edge
    always @(negedge lclk) begin
        if (!lrst) begin
            if (!state_pulse_n && !prev_low) pulses++;
            if (!state_pulse_n && prev_low)  wide++;
            prev_low <= !state_pulse_n;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic hwait(input int n);
        for (int i = 0; i < n; i++) @(negedge hclk);
    endtask

    task automatic lwait(input int n);
        for (int i = 0; i < n; i++) @(negedge lclk);
    endtask

    task automatic reg_write(input logic [15:0] v);
        @(negedge hclk);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge hclk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic t_reset();
        check("R1", "rdata after reset", reg_rdata, 16'h0000);
        check("R1", "evt_n after reset", evt_n, 1);
        check("R1", "strobe after reset", state_pulse_n, 1);
    endtask

    task automatic t_fields();
        int p0 = pulses;
        reg_write(16'h7FFF);
        check("R2", "rdata after all-ones write", reg_rdata, 16'h0103);
        lwait(8);
        check("R3", "strobes after 0->3", pulses - p0, 1);
        check("R4", "wide strobes", wide, 0);
    endtask

    task automatic t_same();
        int p0 = pulses;
        reg_write(16'h0003);
        reg_write(16'h0103);
        lwait(8);
        check("R5", "strobes after unchanged state", pulses - p0, 0);
        check("R2", "rdata after same-state write", reg_rdata, 16'h0103);
    endtask

    task automatic t_multi();
        int p0 = pulses;
        reg_write(16'h0001);
        lwait(8);
        check("R3", "strobe after 3->1", pulses - p0, 1);
        reg_write(16'h0002);
        lwait(8);
        reg_write(16'h0000);
        lwait(8);
        check("R3", "strobes after three changes", pulses - p0, 3);
        check("R4", "wide strobes after sequence", wide, 0);
    endtask

    task automatic t_wake();
        // enable off, state 0
        @(negedge hclk);
        wake_req = 1'b1;
        hwait(2);
        check("R6", "status before third edge", reg_rdata[15], 0);
        hwait(1);
        check("R6", "status at third edge", reg_rdata[15], 1);
        check("R7", "evt_n with enable off", evt_n, 1);
        reg_write(16'h0100);
        check("R8", "status kept after write of 0", reg_rdata[15], 1);
        check("R7", "evt_n with status and enable", evt_n, 0);
        reg_write(16'h8100);
        check("R8", "status after write-one clear", reg_rdata[15], 0);
        check("R7", "evt_n after clear", evt_n, 1);
        hwait(10);
        check("R9", "status with wake held", reg_rdata[15], 0);
        wake_req = 1'b0;
        hwait(5);
        wake_req = 1'b1;
        hwait(4);
        check("R9", "status after new wake edge", reg_rdata[15], 1);
        check("R7", "evt_n after new wake", evt_n, 0);
        wake_req = 1'b0;
    endtask

    initial begin
        hwait(4);
        hrst = 1'b0;
        lrst = 1'b0;
        hwait(2);
        t_reset();
        t_fields();
        t_same();
        t_multi();
        t_wake();
        hwait(4);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule